// File: doc/BRIEF.md
# Control IN Endpoint 0 Control Register

This block holds the software-visible control word of a single device endpoint that sends data to the host. The endpoint is the default control endpoint, number zero, in the IN direction. Software writes and reads the word through a plain 32-bit port with a write strobe. A read returns the current state with no delay.

The packet engine drives three one-cycle event strobes into the block: a transfer has finished, a requested stop has been carried out, and a SETUP packet has arrived. In return the block tells the engine three things: whether the endpoint is armed, whether a stop is pending, and whether every token must be answered with a NAK handshake.

The arm bit and the stop bit are set by software and cleared only by hardware. The block clears them on the same clock edge that raises the matching one-cycle interrupt. Software therefore never sees an interrupt while a stale arm bit is still visible. The NAK state has no writable bit of its own. It changes through two write-only command bits, and a received SETUP packet also forces it on.

Top module: `ep0_in_ctl`

## Requirements
- R1: After reset the read word is 0x00000000, the NAK state is off, and both interrupt outputs are low.
- R2: A write with bit 31 at one arms the endpoint, and bit 31 then reads one. A write with bit 31 at zero never clears it.
- R3: A transfer-done strobe while the endpoint is armed clears bit 31 on the next edge. On that same edge it raises `irq_xfer_done` for exactly one cycle. A transfer-done strobe while the endpoint is not armed has no effect.
- R4: A write with bit 30 at one sets the stop request only if bit 31 is already one before that write. Otherwise bit 30 stays zero. A write with bit 30 at zero never clears a pending stop request.
- R5: A stop-acknowledge strobe while a stop is pending clears bits 31 and 30 together and pulses `irq_ep_disabled` for one cycle. It raises no `irq_xfer_done`, even if a transfer-done strobe arrives in the same cycle. A stop-acknowledge strobe with no stop pending has no effect.
- R6: A write with bit 27 at one turns the NAK state on, and a write with bit 26 at one turns it off. If both bits are one in the same write, the NAK state turns off.
- R7: A SETUP strobe turns the NAK state on. This holds even when a write in the same cycle carries bit 26 at one.
- R8: Bits 29 down to 0 always read zero. This covers the command bits 27 and 26 and the FIFO number field in bits 25:22.
- R9: When a transfer completes while a stop is pending, the stop request is dropped together with bit 31, and only `irq_xfer_done` fires.
- R10: When an arming write and a hardware completion clear fall in the same cycle, the clear wins and bit 31 reads zero afterwards.
- R11: The outputs `ep_armed`, `ep_stop_pend` and `ep_nak` always equal the arm bit, the stop bit and the NAK state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current control word |
| eng_xfer_done | input | 1 | Transfer finished, one-cycle strobe |
| eng_stop_ack | input | 1 | Requested stop carried out, one-cycle strobe |
| eng_setup_rx | input | 1 | SETUP packet received, one-cycle strobe |
| ep_armed | output | 1 | Endpoint armed, data ready to send |
| ep_stop_pend | output | 1 | Stop request pending |
| ep_nak | output | 1 | Answer tokens with NAK |
| irq_xfer_done | output | 1 | Transfer-complete interrupt pulse |
| irq_ep_disabled | output | 1 | Endpoint-disabled interrupt pulse |

## Verification
A wrong arm or stop bit appears on `csr_rdata` and on the status outputs in the cycle after the edge that corrupts it. A wrong clear order shows up as an interrupt pulse while bit 31 still reads one. A lost or doubled completion shows up as a missing interrupt pulse, a second pulse, or the wrong pulse in the cycle after the strobe. A wrong NAK priority shows on `ep_nak` one edge after the write or the SETUP strobe that collides with it. The bench compares all of these outputs against a reference model after every edge, so each fault is caught within one cycle of its cause.

// File: rtl/ep0_in_ctl_pkg.sv
package ep0_in_ctl_pkg;

    localparam int CSR_W      = 32;
    localparam int ARM_BIT    = 31;
    localparam int STOP_BIT   = 30;
    localparam int NAKSET_BIT = 27;
    localparam int NAKCLR_BIT = 26;

    // Stored endpoint state, including the registered interrupt pulses
    typedef struct packed {
        logic armed;
        logic stop;
        logic nak;
        logic irq_xfer;
        logic irq_dis;
    } ep_state_t;

    // Decoded software commands for one write
    typedef struct packed {
        logic arm;
        logic stop;
        logic nak_on;
        logic nak_off;
    } ep_cmd_t;

endpackage

// File: rtl/ep0_in_ctl_dec.sv
module ep0_in_ctl_dec
    import ep0_in_ctl_pkg::*;
#(
    parameter int W = CSR_W
) (
    input  logic         we,
    input  logic [W-1:0] wdata,
    output ep_cmd_t      cmd
);

    always_comb begin
        cmd.arm     = we & wdata[ARM_BIT];
        cmd.stop    = we & wdata[STOP_BIT];
        cmd.nak_on  = we & wdata[NAKSET_BIT];
        cmd.nak_off = we & wdata[NAKCLR_BIT];
    end

endmodule

// File: rtl/ep0_in_ctl_core.sv
module ep0_in_ctl_core
    import ep0_in_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ep_cmd_t   cmd,
    input  logic      xfer_done,
    input  logic      stop_ack,
    input  logic      setup_rx,
    output ep_state_t st_q
);

    ep_state_t st_d;
    logic      stop_cpl;
    logic      xfer_cpl;

    always_comb begin
        // A completed stop takes precedence over a finished transfer
        stop_cpl = stop_ack & st_q.stop;
        xfer_cpl = xfer_done & st_q.armed & ~stop_cpl;

        st_d          = st_q;
        st_d.irq_xfer = xfer_cpl;
        st_d.irq_dis  = stop_cpl;

        if (stop_cpl || xfer_cpl) begin
            st_d.armed = 1'b0;
            st_d.stop  = 1'b0;
        end else begin
            if (cmd.arm)
                st_d.armed = 1'b1;
            if (cmd.stop && st_q.armed)
                st_d.stop = 1'b1;
        end

        if (setup_rx)
            st_d.nak = 1'b1;
        else if (cmd.nak_off)
            st_d.nak = 1'b0;
        else if (cmd.nak_on)
            st_d.nak = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R3
    xfer_irq_arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq_xfer |-> !st_q.armed);

    // R5
    dis_irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq_dis |-> (!st_q.armed && !st_q.stop));

    // R5
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.irq_dis && st_q.irq_xfer));

    // R4
    stop_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stop |-> st_q.armed);

    // R3
    xfer_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq_xfer |=> !st_q.irq_xfer);

    // R7
    setup_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_rx |=> st_q.nak);

    // R2
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !xfer_done && !stop_ack) |=> st_q.armed);

endmodule

// File: rtl/ep0_in_ctl.sv
module ep0_in_ctl
    import ep0_in_ctl_pkg::*;
#(
    parameter int W = CSR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         csr_we,
    input  logic [W-1:0] csr_wdata,
    output logic [W-1:0] csr_rdata,
    input  logic         eng_xfer_done,
    input  logic         eng_stop_ack,
    input  logic         eng_setup_rx,
    output logic         ep_armed,
    output logic         ep_stop_pend,
    output logic         ep_nak,
    output logic         irq_xfer_done,
    output logic         irq_ep_disabled
);

    ep_cmd_t   cmd;
    ep_state_t st_q;

    ep0_in_ctl_dec #(.W(W)) u_dec (
        .we    (csr_we),
        .wdata (csr_wdata),
        .cmd   (cmd)
    );

    ep0_in_ctl_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .xfer_done (eng_xfer_done),
        .stop_ack  (eng_stop_ack),
        .setup_rx  (eng_setup_rx),
        .st_q      (st_q)
    );

    // Only the arm and stop bits are visible; every other bit reads zero
    always_comb begin
        csr_rdata           = '0;
        csr_rdata[ARM_BIT]  = st_q.armed;
        csr_rdata[STOP_BIT] = st_q.stop;
    end

    assign ep_armed        = st_q.armed;
    assign ep_stop_pend    = st_q.stop;
    assign ep_nak          = st_q.nak;
    assign irq_xfer_done   = st_q.irq_xfer;
    assign irq_ep_disabled = st_q.irq_dis;

endmodule

// File: tb/sim_ep0_in_ctl.sv
module sim_ep0_in_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        done = 1'b0, sack = 1'b0, setup = 1'b0;
    logic        armed, stop_pend, nak, ixfer, idis;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    int m_en = 0, m_dis = 0, m_nak = 0, m_ix = 0, m_id = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep0_in_ctl u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_wdata(wdata), .csr_rdata(rdata),
        .eng_xfer_done(done), .eng_stop_ack(sack), .eng_setup_rx(setup),
        .ep_armed(armed), .ep_stop_pend(stop_pend), .ep_nak(nak),
        .irq_xfer_done(ixfer), .irq_ep_disabled(idis)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] exp_rd;
        exp_rd = {m_en[0], m_dis[0], 30'b0};
        check(rdata[31] == m_en[0], "R2 arm bit", rdata[31], m_en);
        check(rdata[30] == m_dis[0], "R4 stop bit", rdata[30], m_dis);
        check(rdata[29:0] == 30'b0, "R8 zero bits", rdata[29:0], 0);
        check(rdata == exp_rd, "R8 read word", rdata, exp_rd);
        check(ixfer == m_ix[0], "R3 irq_xfer_done", ixfer, m_ix);
        check(idis == m_id[0], "R5 irq_ep_disabled", idis, m_id);
        check(nak == m_nak[0], "R6 nak state", nak, m_nak);
        check(armed == m_en[0] && stop_pend == m_dis[0], "R11 status outputs",
              {armed, stop_pend}, {m_en[0], m_dis[0]});
    endtask

    task automatic step(input bit w, input logic [31:0] d, input bit dn, input bit sa, input bit su);
        int dis_cpl, xf_cpl, n_en, n_dis, n_nak;
        @(negedge clk);
        we = w; wdata = d; done = dn; sack = sa; setup = su;
        dis_cpl = (sa && m_dis != 0) ? 1 : 0;
        xf_cpl  = (dn && m_en != 0 && dis_cpl == 0) ? 1 : 0;
        if (dis_cpl != 0 || xf_cpl != 0) begin
            n_en = 0; n_dis = 0;
        end else begin
            n_en  = (m_en != 0 || (w && d[31])) ? 1 : 0;
            n_dis = (m_dis != 0 || (w && d[30] && m_en != 0)) ? 1 : 0;
        end
        if (su) n_nak = 1;
        else if (w && d[26]) n_nak = 0;
        else if (w && d[27]) n_nak = 1;
        else n_nak = m_nak;
        @(posedge clk);
        #1;
        m_en = n_en; m_dis = n_dis; m_nak = n_nak; m_ix = xf_cpl; m_id = dis_cpl;
        compare_all();
    endtask

    task automatic idle();
        step(0, 32'h0, 0, 0, 0);
    endtask

    task automatic wr(input logic [31:0] d);
        step(1, d, 0, 0, 0);
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!finished && cyc < WDOG_LIMIT) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG_LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(rdata == 32'h0 && nak == 1'b0 && ixfer == 1'b0 && idis == 1'b0, "R1 reset",
              {rdata, nak, ixfer, idis}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R4: stop request while not armed is dropped
        wr(32'h4000_0000);
        check(rdata[30] == 1'b0, "R4 stop without arm", rdata[30], 0);
        // R2: arm, then a zero write keeps it
        wr(32'h8000_0000);
        wr(32'h0000_0000);
        check(rdata[31] == 1'b1, "R2 zero write keeps arm", rdata[31], 1);
        // R5: stop, then ack together with done
        wr(32'h4000_0000);
        step(0, 32'h0, 1, 1, 0);
        check(idis == 1'b1 && ixfer == 1'b0 && rdata[31:30] == 2'b00, "R5 stop completion",
              {idis, ixfer, rdata[31:30]}, 4'b1000);
        idle();
        check(idis == 1'b0, "R5 single pulse", idis, 0);
        // R5: ack with nothing pending
        step(0, 32'h0, 0, 1, 0);
        // R3: normal completion
        wr(32'h8000_0000);
        step(0, 32'h0, 1, 0, 0);
        check(ixfer == 1'b1 && rdata[31] == 1'b0, "R3 completion", {ixfer, rdata[31]}, 2'b10);
        step(0, 32'h0, 1, 0, 0);
        check(ixfer == 1'b0, "R3 done while idle ignored", ixfer, 0);
        // R9: completion drops a pending stop
        wr(32'h8000_0000);
        wr(32'h4000_0000);
        step(0, 32'h0, 1, 0, 0);
        check(rdata[31:30] == 2'b00 && ixfer == 1'b1 && idis == 1'b0, "R9 completion with stop",
              {rdata[31:30], ixfer, idis}, 4'b0010);
        // R10: arming write collides with completion
        wr(32'h8000_0000);
        step(1, 32'h8000_0000, 1, 0, 0);
        check(rdata[31] == 1'b0, "R10 clear wins", rdata[31], 0);
        // R6: NAK commands
        wr(32'h0800_0000);
        check(nak == 1'b1, "R6 set nak", nak, 1);
        wr(32'h0400_0000);
        check(nak == 1'b0, "R6 clear nak", nak, 0);
        wr(32'h0800_0000);
        wr(32'h0C00_0000);
        check(nak == 1'b0, "R6 both -> clear", nak, 0);
        // R7: SETUP forces NAK, also over a clear command
        step(0, 32'h0, 0, 0, 1);
        check(nak == 1'b1, "R7 setup sets nak", nak, 1);
        step(1, 32'h0400_0000, 0, 0, 1);
        check(nak == 1'b1, "R7 setup beats clear", nak, 1);
        // R8: all-ones write shows only the arm bit
        wr(32'hFFFF_FFFF);
        check(rdata == 32'h8000_0000, "R8 all ones write", rdata, 32'h8000_0000);
        wr(32'hFFFF_FFFF);
        check(rdata == 32'hC000_0000, "R8 arm and stop", rdata, 32'hC000_0000);
        step(0, 32'h0, 0, 1, 0);
        idle();
        idle();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule